// File: doc/BRIEF.md
# Seconds Timekeeper with Committed Commands

This block keeps wall-clock time in seconds as the sum of two 32-bit quantities: a base value that software sets and a counter that advances on every pulse of a seconds-tick input. A small 16-bit register file lets the host stage 32-bit write data in two halves. A control register holds command bits. The host collects results from a 32-bit read-data register and from a 32-bit counter snapshot, each read as two halves. The block also keeps two 32-bit general-purpose flags, which software uses to mark the stored time as valid.

Command bits do nothing when written. They are committed only when the isolation-enable input rises, and each rise commits them once. The unlock handshake that produces this pulse lies outside the block. To set the time, software writes the base, then clears the counter, then writes 1 into flag 0. To read the time, software reads the base and then takes a counter snapshot, which needs an arm command followed by a trigger write. The sum of base and counter is also driven directly on an output.

Top module: `tk_timekeeper`

## Requirements
- R1: After reset, every register reads 0 and `now_sec` is 0.
- R2: Host writes go to the control register (byte offset 0x00) and to the write-data halves (low 0x10, high 0x14), and these read back unchanged. The read-data halves sit at 0x24/0x28 and the snapshot halves at 0x30/0x34. Any other offset, including the trigger at 0x38, reads 0.
- R3: Control bits act only on a rising edge of `iso_en`, and act once for each rise. Holding `iso_en` high, or changing write data while it stays high, has no further effect.
- R4: Control bit 1 loads the base from write data {high, low}.
- R5: Control bit 2 copies the base into the read-data halves.
- R6: Control bit 3 clears the counter to 0. It wins over a seconds tick in the same cycle.
- R7: The counter advances by one, modulo 2^32, on each cycle in which `sec_tick` is high.
- R8: `now_sec` equals base plus counter, modulo 2^32.
- R9: Bits 5 and 6 load flag 0 and flag 1 from write data. Bits 7 and 8 copy flag 0 or flag 1 into read data. When several copy bits are set at once, the base (bit 2) wins over flag 0, and flag 0 wins over flag 1.
- R10: Bit 0 arms a snapshot. Writing 1 to bit 0 at offset 0x38 while armed copies the counter into the snapshot halves and disarms. A trigger while not armed is ignored. The snapshot holds its value until the next armed trigger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | 8 | Host write byte offset |
| wr_data | input | 16 | Host write data |
| rd_addr | input | 8 | Host read byte offset |
| rd_data | output | 16 | Host read data (combinational) |
| iso_en | input | 1 | Isolation enable; its rising edge commits the commands |
| sec_tick | input | 1 | One-cycle seconds tick |
| now_sec | output | 32 | Base plus counter |

## Verification
The assertions check the counter on every cycle: it steps by one on a tick, holds otherwise, and clears after a reset command. They also check that the base and the snapshot change only when their commands are committed, and that a commit never fires on two cycles in a row. Some behaviours can only be shown by the bench's scenarios. These are the values that land in read data, the copy priority among the read commands, a trigger ignored while not armed, write data changed while the enable stays high, and the sum wrapping past 2^32.

// File: rtl/tk_pkg.sv
package tk_pkg;
    localparam int unsigned TK_A_CTRL  = 'h00;
    localparam int unsigned TK_A_WLO   = 'h10;
    localparam int unsigned TK_A_WHI   = 'h14;
    localparam int unsigned TK_A_RLO   = 'h24;
    localparam int unsigned TK_A_RHI   = 'h28;
    localparam int unsigned TK_A_SLO   = 'h30;
    localparam int unsigned TK_A_SHI   = 'h34;
    localparam int unsigned TK_A_TRIG  = 'h38;

    localparam int unsigned TK_B_ARM     = 0;
    localparam int unsigned TK_B_BASE_WR = 1;
    localparam int unsigned TK_B_BASE_RD = 2;
    localparam int unsigned TK_B_CNT_RST = 3;
    localparam int unsigned TK_B_F0_WR   = 5;
    localparam int unsigned TK_B_F1_WR   = 6;
    localparam int unsigned TK_B_F0_RD   = 7;
    localparam int unsigned TK_B_F1_RD   = 8;

    typedef struct packed {
        logic cnt_arm;
        logic base_wr;
        logic base_rd;
        logic cnt_rst;
        logic f0_wr;
        logic f1_wr;
        logic f0_rd;
        logic f1_rd;
    } tk_cmd_t;
endpackage

// File: rtl/tk_regs.sv
module tk_regs
    import tk_pkg::*;
#(
    parameter int unsigned HALF_W = 16,
    parameter int unsigned ADDR_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [HALF_W-1:0]   wr_data,
    input  logic [ADDR_W-1:0]   rd_addr,
    output logic [HALF_W-1:0]   rd_data,
    input  logic [2*HALF_W-1:0] rdata_val,
    input  logic [2*HALF_W-1:0] snap_val,
    output logic [HALF_W-1:0]   ctrl,
    output logic [2*HALF_W-1:0] wdata,
    output logic                trig
);
    typedef struct packed {
        logic [HALF_W-1:0] ctrl;
        logic [HALF_W-1:0] wlo;
        logic [HALF_W-1:0] whi;
    } regs_t;

    regs_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        trig = 1'b0;
        if (wr_en) begin
            if (wr_addr == ADDR_W'(TK_A_CTRL)) st_d.ctrl = wr_data;
            if (wr_addr == ADDR_W'(TK_A_WLO))  st_d.wlo  = wr_data;
            if (wr_addr == ADDR_W'(TK_A_WHI))  st_d.whi  = wr_data;
            if (wr_addr == ADDR_W'(TK_A_TRIG)) trig      = wr_data[0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        rd_data = '0;
        if (rd_addr == ADDR_W'(TK_A_CTRL)) rd_data = st_q.ctrl;
        if (rd_addr == ADDR_W'(TK_A_WLO))  rd_data = st_q.wlo;
        if (rd_addr == ADDR_W'(TK_A_WHI))  rd_data = st_q.whi;
        if (rd_addr == ADDR_W'(TK_A_RLO))  rd_data = rdata_val[HALF_W-1:0];
        if (rd_addr == ADDR_W'(TK_A_RHI))  rd_data = rdata_val[2*HALF_W-1:HALF_W];
        if (rd_addr == ADDR_W'(TK_A_SLO))  rd_data = snap_val[HALF_W-1:0];
        if (rd_addr == ADDR_W'(TK_A_SHI))  rd_data = snap_val[2*HALF_W-1:HALF_W];
    end

    assign ctrl  = st_q.ctrl;
    assign wdata = {st_q.whi, st_q.wlo};

    // R2: a write to the control offset is visible in the control register next cycle
    p_ctrl_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADDR_W'(TK_A_CTRL)) |=> (ctrl == $past(wr_data)));
endmodule

// File: rtl/tk_cmd.sv
module tk_cmd
    import tk_pkg::*;
#(
    parameter int unsigned HALF_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              iso_en,
    input  logic [HALF_W-1:0] ctrl,
    output tk_cmd_t           cmd,
    output logic              fire
);
    typedef struct packed {
        logic iso_prev;
    } edge_t;

    edge_t st_d, st_q;

    always_comb begin
        st_d          = st_q;
        st_d.iso_prev = iso_en;
        fire          = iso_en && !st_q.iso_prev;
        cmd           = '0;
        if (fire) begin
            cmd.cnt_arm = ctrl[TK_B_ARM];
            cmd.base_wr = ctrl[TK_B_BASE_WR];
            cmd.base_rd = ctrl[TK_B_BASE_RD];
            cmd.cnt_rst = ctrl[TK_B_CNT_RST];
            cmd.f0_wr   = ctrl[TK_B_F0_WR];
            cmd.f1_wr   = ctrl[TK_B_F1_WR];
            cmd.f0_rd   = ctrl[TK_B_F0_RD];
            cmd.f1_rd   = ctrl[TK_B_F1_RD];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    logic unused_ctrl_bits;
    assign unused_ctrl_bits = ^{ctrl[HALF_W-1:TK_B_F1_RD+1], ctrl[4]};

    // R3: one commit per rising edge, never on two cycles in a row
    p_once_per_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> !fire);
endmodule

// File: rtl/tk_core.sv
module tk_core
    import tk_pkg::*;
#(
    parameter int unsigned TIME_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  tk_cmd_t           cmd,
    input  logic [TIME_W-1:0] wdata,
    input  logic              tick,
    input  logic              trig,
    output logic [TIME_W-1:0] rdata_val,
    output logic [TIME_W-1:0] snap_val,
    output logic [TIME_W-1:0] now_sec
);
    localparam int unsigned NFLAG = 2;

    typedef struct packed {
        logic [TIME_W-1:0]            base;
        logic [TIME_W-1:0]            cnt;
        logic [NFLAG-1:0][TIME_W-1:0] flag;
        logic [TIME_W-1:0]            rdat;
        logic [TIME_W-1:0]            snap;
        logic                         armed;
    } core_t;

    core_t st_d, st_q;
    logic [NFLAG-1:0] flag_wr;
    logic [NFLAG-1:0] flag_rd;

    assign flag_wr = {cmd.f1_wr, cmd.f0_wr};
    assign flag_rd = {cmd.f1_rd, cmd.f0_rd};

    always_comb begin
        st_d = st_q;

        if (cmd.cnt_rst)   st_d.cnt = '0;
        else if (tick)     st_d.cnt = st_q.cnt + TIME_W'(1);

        if (cmd.base_wr)   st_d.base = wdata;

        for (int i = 0; i < NFLAG; i++) begin
            if (flag_wr[i]) st_d.flag[i] = wdata;
        end

        // copy priority: base, then lowest-numbered flag
        if (cmd.base_rd) begin
            st_d.rdat = st_q.base;
        end else begin
            for (int i = NFLAG - 1; i >= 0; i--) begin
                if (flag_rd[i]) st_d.rdat = st_q.flag[i];
            end
        end

        if (trig && st_q.armed) begin
            st_d.snap  = st_q.cnt;
            st_d.armed = 1'b0;
        end
        if (cmd.cnt_arm) st_d.armed = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rdata_val = st_q.rdat;
    assign snap_val  = st_q.snap;
    assign now_sec   = st_q.base + st_q.cnt;

    // R7: counter steps by one per tick, wrapping
    p_cnt_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !cmd.cnt_rst) |=> (st_q.cnt == TIME_W'($past(st_q.cnt) + TIME_W'(1))));
    // R7: counter holds without a tick
    p_cnt_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !cmd.cnt_rst) |=> $stable(st_q.cnt));
    // R6: reset command clears the counter
    p_cnt_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cmd.cnt_rst |=> (st_q.cnt == '0));
    // R4: base changes only on a committed base write
    p_base_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd.base_wr |=> $stable(st_q.base));
    // R10: snapshot changes only on an armed trigger
    p_snap_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(trig && st_q.armed) |=> $stable(st_q.snap));
endmodule

// File: rtl/tk_timekeeper.sv
module tk_timekeeper
    import tk_pkg::*;
#(
    parameter int unsigned HALF_W = 16,
    parameter int unsigned ADDR_W = 8,
    localparam int unsigned TIME_W = 2 * HALF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [HALF_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [HALF_W-1:0] rd_data,
    input  logic              iso_en,
    input  logic              sec_tick,
    output logic [TIME_W-1:0] now_sec
);
    logic [HALF_W-1:0] ctrl;
    logic [TIME_W-1:0] wdata;
    logic [TIME_W-1:0] rdata_val;
    logic [TIME_W-1:0] snap_val;
    logic              trig;
    logic              fire;
    tk_cmd_t           cmd;

    tk_regs #(.HALF_W(HALF_W), .ADDR_W(ADDR_W)) i_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .rdata_val(rdata_val),
        .snap_val (snap_val),
        .ctrl     (ctrl),
        .wdata    (wdata),
        .trig     (trig)
    );

    tk_cmd #(.HALF_W(HALF_W)) i_cmd (
        .clk   (clk),
        .rst_n (rst_n),
        .iso_en(iso_en),
        .ctrl  (ctrl),
        .cmd   (cmd),
        .fire  (fire)
    );

    tk_core #(.TIME_W(TIME_W)) i_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd      (cmd),
        .wdata    (wdata),
        .tick     (sec_tick),
        .trig     (trig),
        .rdata_val(rdata_val),
        .snap_val (snap_val),
        .now_sec  (now_sec)
    );

    // R3: without a rising enable edge no command reaches the core
    p_no_cmd_without_edge_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !fire |-> (cmd == '0));
endmodule

// File: tb/test_tk_timekeeper.sv
module test_tk_timekeeper;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [7:0]  rd_addr = '0;
    logic [15:0] rd_data;
    logic        iso_en = 1'b0;
    logic        sec_tick = 1'b0;
    logic [31:0] now_sec;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    typedef struct {
        logic [7:0]  addr;
        bit          is_now;
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t q[$];

    always #4 clk = ~clk;

    tk_timekeeper i_tk_timekeeper (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .iso_en(iso_en), .sec_tick(sec_tick), .now_sec(now_sec)
    );

    // monitor: pops expected items and compares against the ports
    initial begin
        forever begin
            wait (q.size() > 0);
            begin
                item_t it;
                logic [31:0] act;
                it = q[0];
                rd_addr = it.addr;
                #1;
                act = it.is_now ? now_sec : {16'h0, rd_data};
                n_chk++;
                if (act !== it.exp) begin
                    n_bad++;
                    $display("FAIL %s addr=%02h actual=%08h expected=%08h",
                             it.tag, it.addr, act, it.exp);
                end
                void'(q.pop_front());
            end
        end
    end

    task automatic expect_reg(input logic [7:0] a, input logic [15:0] v, input string tag);
        item_t it;
        it.addr = a; it.is_now = 1'b0; it.exp = {16'h0, v}; it.tag = tag;
        q.push_back(it);
        wait (q.size() == 0);
        @(negedge clk);
    endtask

    task automatic expect_now(input logic [31:0] v, input string tag);
        item_t it;
        it.addr = 8'h00; it.is_now = 1'b1; it.exp = v; it.tag = tag;
        q.push_back(it);
        wait (q.size() == 0);
        @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [15:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pulse(input int len);
        iso_en = 1'b1;
        repeat (len) @(negedge clk);
        iso_en = 1'b0;
        @(negedge clk);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            sec_tick = 1'b1;
            @(negedge clk);
            sec_tick = 1'b0;
        end
    endtask

    task automatic wr32(input logic [31:0] v);
        wr(8'h10, v[15:0]);
        wr(8'h14, v[31:16]);
    endtask

    task automatic command(input logic [15:0] bits);
        wr(8'h00, bits);
        pulse(2);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        expect_reg(8'h00, 16'h0, "R1 ctrl");
        expect_reg(8'h24, 16'h0, "R1 rdata lo");
        expect_reg(8'h34, 16'h0, "R1 snap hi");
        expect_now(32'h0, "R1 now");

        // R2: register write / readback, unmapped offsets
        wr32(32'h1234_5678);
        wr(8'h00, 16'h0002);
        expect_reg(8'h10, 16'h5678, "R2 wdata lo");
        expect_reg(8'h14, 16'h1234, "R2 wdata hi");
        expect_reg(8'h00, 16'h0002, "R2 ctrl");
        wr(8'h04, 16'hFFFF);
        expect_reg(8'h04, 16'h0, "R2 unmapped");
        expect_reg(8'h38, 16'h0, "R2 trigger reads 0");

        // R3: command bit set but no pulse -> no effect
        repeat (3) @(negedge clk);
        expect_now(32'h0, "R3 no pulse");

        // R4 + R3: pulse held high while write data changes
        iso_en = 1'b1;
        @(negedge clk);
        wr(8'h10, 16'hAAAA);
        repeat (2) @(negedge clk);
        iso_en = 1'b0;
        @(negedge clk);
        expect_now(32'h1234_5678, "R4 R3 base once per pulse");
        wr(8'h10, 16'h5678);

        // R5: base read
        command(16'h0004);
        expect_reg(8'h24, 16'h5678, "R5 rdata lo");
        expect_reg(8'h28, 16'h1234, "R5 rdata hi");

        // R7 R8: ticks
        ticks(3);
        expect_now(32'h1234_567B, "R7 R8 three ticks");

        // R6: counter reset wins over a tick in the same cycle
        wr(8'h00, 16'h0008);
        iso_en = 1'b1; sec_tick = 1'b1;
        @(negedge clk);
        sec_tick = 1'b0;
        @(negedge clk);
        iso_en = 1'b0;
        @(negedge clk);
        expect_now(32'h1234_5678, "R6 reset beats tick");

        // R9: flags and copy priority
        wr32(32'hA5A5_0001);
        command(16'h0020);
        wr32(32'h0000_BEEF);
        command(16'h0040);
        command(16'h0080);
        expect_reg(8'h24, 16'h0001, "R9 flag0 lo");
        expect_reg(8'h28, 16'hA5A5, "R9 flag0 hi");
        command(16'h0100);
        expect_reg(8'h24, 16'hBEEF, "R9 flag1 lo");
        expect_reg(8'h28, 16'h0000, "R9 flag1 hi");
        command(16'h0180);
        expect_reg(8'h28, 16'hA5A5, "R9 flag0 over flag1");
        command(16'h0084);
        expect_reg(8'h28, 16'h1234, "R9 base over flag0");
        expect_now(32'h1234_5678, "R9 flag write leaves base");

        // R10: trigger without arm ignored
        ticks(5);
        wr(8'h38, 16'h0001);
        expect_reg(8'h30, 16'h0, "R10 unarmed trigger ignored");
        // arm then trigger
        command(16'h0001);
        wr(8'h38, 16'h0001);
        expect_reg(8'h30, 16'h0005, "R10 snap lo");
        expect_reg(8'h34, 16'h0000, "R10 snap hi");
        ticks(2);
        wr(8'h38, 16'h0001);
        expect_reg(8'h30, 16'h0005, "R10 snap holds, disarmed");
        command(16'h0001);
        wr(8'h38, 16'h0001);
        expect_reg(8'h30, 16'h0007, "R10 rearmed snap");

        // R8: sum wraps
        wr32(32'hFFFF_FFFF);
        command(16'h0002);
        command(16'h0008);
        ticks(2);
        expect_now(32'h0000_0001, "R8 wrap");

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule